// File: doc/BRIEF.md
# SDLC Frame Transmitter with Deferred RTS Release

This block turns a stream of host bytes into bit-oriented SDLC frames on a single serial line. Each frame opens with a flag. The payload bytes follow, least significant bit first, and the block inserts a zero after any five consecutive ones. When the host has no byte ready at a byte boundary, the block treats this as an underrun and closes the frame. It sends a 16-bit frame check sequence and then a closing flag. Between frames the line either idles at mark or repeats flags, as configured. Bits advance only on cycles where the bit-rate enable is high.

The active-low request-to-send pin is driven from a control bit. In the deferred-release mode, the underrun handler in software may clear that bit as soon as the underrun is reported. The pin then stays asserted while the check sequence and closing flag go out. It is released only when the final zero of the closing flag has finished its bit period on the line. Outside that mode, clearing the bit releases the pin on the next clock edge.

Top module: `sdlc_tx_autorts`

## Requirements
- R1: While reset is held, txd is 1, rts_n is 1, eom is 0 and in_ready is 0.
- R2: A frame starts at the first bit slot in which in_valid is high while idle (with flag idle, only at a flag boundary). The frame is the flag 0x7E, then each accepted byte LSB first, then the 16-bit check sequence, then 0x7E. The check sequence uses the reflected polynomial 0x8408, is preset to 0xFFFF, is updated per data bit LSB first, and is sent inverted, LSB first. A byte is taken when in_ready and in_valid are both high.
- R3: After five consecutive 1 bits of data or check sequence, a 0 is sent before the next bit, including before the closing flag. No 0 is inserted inside flags.
- R4: eom rises at the bit-slot edge that sends the last data bit when no byte is offered at that boundary. It falls at the edge that sends the last bit of the closing flag.
- R5: Mode bit 3 = 1 holds txd at 1 between frames. Mode bit 3 = 0 repeats 0x7E between frames.
- R6: Writing 1 to control bit 0 (address 0) drives rts_n low after the next clock edge.
- R7: The deferred mode is active when mode bits 0, 1, 2 and 3 are 1 and mode bit 4 is 0 (address 1). In this mode, clearing control bit 0 during a frame keeps rts_n low. rts_n goes high at the first bit-slot edge after the last closing-flag bit was sent.
- R8: When any of those mode conditions fails, clearing control bit 0 drives rts_n high after the next clock edge, even mid-frame.
- R9: txd changes only at clock edges where bit_en was high.
- R10: in_ready is high only in cycles where bit_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = control (bit 0 RTS request), 1 = mode |
| cfg_wdata | input | 5 | Write data; mode bits: 0 SDLC, 1 extended, 2 deferred RTS, 3 mark idle, 4 abort-on-underrun |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Byte taken this cycle |
| bit_en | input | 1 | One-cycle bit-rate strobe |
| txd | output | 1 | Serial data line |
| rts_n | output | 1 | Request to send, active low |
| eom | output | 1 | Underrun / end-of-message status |

## Verification
A wrong bit counter or a wrong stuffing count shows on txd within one byte time. The captured bit stream then differs from the expected frame at a definite bit index. A stale check-sequence register corrupts the 16 bits after the last data bit. A fault in the busy or hold state moves the rts_n rising edge away from the bit slot that follows the closing flag, by at least one bit period. A wrong mode gate makes rts_n rise one clock after the clearing write instead of about twenty bit periods later.

// File: rtl/sdlc_tx_pkg.sv
// Shared types and constants for the SDLC transmitter.
// Assumes mode bit positions are fixed by the struct field order below.
package sdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFLAG,
        ST_DATA,
        ST_CRC,
        ST_CFLAG
    } tx_state_e;

    // Mode register; the last field is bit 0.
    typedef struct packed {
        logic abort_ur;
        logic mark_idle;
        logic auto_rts;
        logic ext_en;
        logic sdlc_mode;
    } mode_t;

    localparam int         CFG_W        = $bits(mode_t);
    localparam logic       ADDR_CTRL    = 1'b0;
    localparam logic       ADDR_MODE    = 1'b1;
    localparam int         CTRL_RTS_BIT = 0;
    localparam int         FLAG_LEN     = 8;
    localparam logic [7:0] FLAG_PATTERN = 8'h7E;

endpackage

// File: rtl/sdlc_cfg_regs.sv
// Configuration storage: RTS request bit and mode register.
// Assumes one write per cycle; values reset to zero.
module sdlc_cfg_regs
    import sdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             rts_req,
    output mode_t            mode
);

    // Capture control and mode writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts_req <= 1'b0;
            mode    <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_CTRL) begin
                rts_req <= cfg_wdata[CTRL_RTS_BIT];
            end else begin
                mode <= mode_t'(cfg_wdata);
            end
        end
    end

endmodule

// File: rtl/sdlc_crc_acc.sv
// Bit-serial frame check accumulator, reflected form (LSB first).
// Assumes init and adv are never both meaningful in one cycle; init wins.
module sdlc_crc_acc #(
    parameter int               CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h8408,
    parameter logic [CRC_W-1:0] INIT  = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             adv,
    input  logic             din,
    output logic [CRC_W-1:0] crc_q,
    output logic [CRC_W-1:0] crc_nx
);

    // Next value after shifting one data bit in.
    always_comb begin
        crc_nx = crc_q >> 1;
        if (crc_q[0] ^ din) begin
            crc_nx = crc_nx ^ POLY;
        end
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= INIT;
        end else if (init) begin
            crc_q <= INIT;
        end else if (adv) begin
            crc_q <= crc_nx;
        end
    end

endmodule

// File: rtl/sdlc_framer.sv
// Frame sequencer: flags, payload, check sequence, zero insertion and idle fill.
// Assumes DATA_W <= CRC_W. All state moves only on bit_en.
module sdlc_framer
    import sdlc_tx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CRC_W    = 16,
    parameter int ONES_MAX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              mark_idle,
    input  logic [CRC_W-1:0]  crc_q,
    input  logic [CRC_W-1:0]  crc_nx,
    output logic              in_ready,
    output logic              crc_init,
    output logic              crc_adv,
    output logic              crc_din,
    output logic              txd,
    output logic              eom,
    output logic              line_busy
);

    localparam int CNT_W  = $clog2(CRC_W);
    localparam int FCNT_W = $clog2(FLAG_LEN);
    localparam int ONES_W = $clog2(ONES_MAX + 1);

    tx_state_e         state, state_d;
    logic [CRC_W-1:0]  sh, sh_d;
    logic [CNT_W-1:0]  bcnt, bcnt_d;
    logic [FCNT_W-1:0] fcnt, fcnt_d;
    logic [ONES_W-1:0] ones, ones_d;
    logic              txd_d, eom_d, busy_d;
    logic              stuff, byte_last, crc_last, flag_last, start, cur_bit;

    // Decode the current slot.
    always_comb begin
        stuff     = (ones == ONES_W'(ONES_MAX)) &&
                    (state == ST_DATA || state == ST_CRC || state == ST_CFLAG);
        byte_last = (bcnt == CNT_W'(DATA_W - 1));
        crc_last  = (bcnt == CNT_W'(CRC_W - 1));
        flag_last = (fcnt == FCNT_W'(FLAG_LEN - 1));
        cur_bit   = sh[bcnt];
        start     = bit_en && (state == ST_IDLE) && in_valid &&
                    (mark_idle || fcnt == '0);
        in_ready  = bit_en && ((state == ST_OFLAG && flag_last) ||
                               (state == ST_DATA && !stuff && byte_last));
        crc_init  = start;
        crc_adv   = bit_en && (state == ST_DATA) && !stuff;
        crc_din   = cur_bit;
    end

    // Next-slot computation.
    always_comb begin
        state_d = state;
        sh_d    = sh;
        bcnt_d  = bcnt;
        fcnt_d  = fcnt;
        ones_d  = ones;
        txd_d   = txd;
        eom_d   = eom;
        busy_d  = line_busy;
        case (state)
            ST_IDLE: begin
                busy_d = 1'b0;
                ones_d = '0;
                if (start) begin
                    txd_d   = FLAG_PATTERN[0];
                    fcnt_d  = FCNT_W'(1);
                    state_d = ST_OFLAG;
                    busy_d  = 1'b1;
                end else if (mark_idle) begin
                    txd_d  = 1'b1;
                    fcnt_d = '0;
                end else begin
                    txd_d  = FLAG_PATTERN[fcnt];
                    fcnt_d = fcnt + 1'b1;
                end
            end
            ST_OFLAG: begin
                txd_d  = FLAG_PATTERN[fcnt];
                fcnt_d = fcnt + 1'b1;
                ones_d = '0;
                if (flag_last) begin
                    bcnt_d = '0;
                    if (in_valid) begin
                        sh_d    = CRC_W'(in_data);
                        state_d = ST_DATA;
                    end else begin
                        sh_d    = ~crc_q;
                        state_d = ST_CRC;
                        eom_d   = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (stuff) begin
                    txd_d  = 1'b0;
                    ones_d = '0;
                end else begin
                    txd_d  = cur_bit;
                    ones_d = cur_bit ? ones + 1'b1 : '0;
                    bcnt_d = bcnt + 1'b1;
                    if (byte_last) begin
                        bcnt_d = '0;
                        if (in_valid) begin
                            sh_d = CRC_W'(in_data);
                        end else begin
                            sh_d    = ~crc_nx;
                            state_d = ST_CRC;
                            eom_d   = 1'b1;
                        end
                    end
                end
            end
            ST_CRC: begin
                if (stuff) begin
                    txd_d  = 1'b0;
                    ones_d = '0;
                end else begin
                    txd_d  = cur_bit;
                    ones_d = cur_bit ? ones + 1'b1 : '0;
                    bcnt_d = bcnt + 1'b1;
                    if (crc_last) begin
                        bcnt_d  = '0;
                        fcnt_d  = '0;
                        state_d = ST_CFLAG;
                    end
                end
            end
            ST_CFLAG: begin
                ones_d = '0;
                if (stuff) begin
                    txd_d = 1'b0;
                end else begin
                    txd_d  = FLAG_PATTERN[fcnt];
                    fcnt_d = fcnt + 1'b1;
                    if (flag_last) begin
                        state_d = ST_IDLE;
                        eom_d   = 1'b0;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Sequencer registers, advanced once per bit slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sh        <= '0;
            bcnt      <= '0;
            fcnt      <= '0;
            ones      <= '0;
            txd       <= 1'b1;
            eom       <= 1'b0;
            line_busy <= 1'b0;
        end else if (bit_en) begin
            state     <= state_d;
            sh        <= sh_d;
            bcnt      <= bcnt_d;
            fcnt      <= fcnt_d;
            ones      <= ones_d;
            txd       <= txd_d;
            eom       <= eom_d;
            line_busy <= busy_d;
        end
    end

endmodule

// File: rtl/sdlc_rts_ctrl.sv
// RTS pin driver with optional deferred release until the line falls quiet.
// Assumes line_busy falls one bit slot after the closing flag's last bit.
module sdlc_rts_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rts_req,
    input  logic auto_act,
    input  logic line_busy,
    output logic rts_n
);

    logic hold_q;

    // Remember that RTS was requested during the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= auto_act && line_busy && (rts_req || hold_q);
        end
    end

    // Pin is low while requested, or while held for a frame in flight.
    always_comb begin
        rts_n = !(rts_req || (hold_q && line_busy && auto_act));
    end

endmodule

// File: rtl/sdlc_tx_autorts.sv
// SDLC transmitter top: configuration, framer, check accumulator, RTS driver.
// Assumes bit_en is a single-cycle strobe at the line bit rate.
module sdlc_tx_autorts
    import sdlc_tx_pkg::*;
#(
    parameter int               DATA_W   = 8,
    parameter int               CRC_W    = 16,
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
    parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF,
    parameter int               ONES_MAX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              bit_en,
    output logic              txd,
    output logic              rts_n,
    output logic              eom
);

    logic             rts_req;
    mode_t            mode;
    logic             auto_act;
    logic             line_busy;
    logic             crc_init, crc_adv, crc_din;
    logic [CRC_W-1:0] crc_q, crc_nx;

    // Deferred release needs every enabling condition at once.
    always_comb begin
        auto_act = mode.sdlc_mode && mode.ext_en && mode.auto_rts &&
                   mode.mark_idle && !mode.abort_ur;
    end

    sdlc_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rts_req   (rts_req),
        .mode      (mode)
    );

    sdlc_crc_acc #(
        .CRC_W (CRC_W),
        .POLY  (CRC_POLY),
        .INIT  (CRC_INIT)
    ) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (crc_init),
        .adv    (crc_adv),
        .din    (crc_din),
        .crc_q  (crc_q),
        .crc_nx (crc_nx)
    );

    sdlc_framer #(
        .DATA_W   (DATA_W),
        .CRC_W    (CRC_W),
        .ONES_MAX (ONES_MAX)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .mark_idle (mode.mark_idle),
        .crc_q     (crc_q),
        .crc_nx    (crc_nx),
        .in_ready  (in_ready),
        .crc_init  (crc_init),
        .crc_adv   (crc_adv),
        .crc_din   (crc_din),
        .txd       (txd),
        .eom       (eom),
        .line_busy (line_busy)
    );

    sdlc_rts_ctrl u_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .rts_req   (rts_req),
        .auto_act  (auto_act),
        .line_busy (line_busy),
        .rts_n     (rts_n)
    );

endmodule

// File: rtl/sdlc_tx_autorts_chk.sv
// Property checker for the SDLC transmitter, bound into the top.
// Assumes the top exposes line_busy and auto_act as internal nets.
module sdlc_tx_autorts_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic txd,
    input logic rts_n,
    input logic in_ready,
    input logic eom,
    input logic cfg_we,
    input logic cfg_addr,
    input logic cfg_rts_bit,
    input logic line_busy,
    input logic auto_act
);

    assert_txd_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bit_en)) |-> $stable(txd));

    assert_ready_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> bit_en);

    assert_rts_assert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 1'b0 && cfg_rts_bit) |=> !rts_n);

    assert_rts_plain_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 1'b0 && !cfg_rts_bit && !auto_act) |=> rts_n);

    assert_rts_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_act && line_busy && !rts_n && !cfg_we) |=> (!rts_n || !line_busy));

    assert_eom_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eom |-> line_busy);

endmodule

bind sdlc_tx_autorts sdlc_tx_autorts_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .txd         (txd),
    .rts_n       (rts_n),
    .in_ready    (in_ready),
    .eom         (eom),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_rts_bit (cfg_wdata[0]),
    .line_busy   (line_busy),
    .auto_act    (auto_act)
);

// File: tb/tb_sdlc_tx_autorts.sv
module tb_sdlc_tx_autorts;

    localparam int BIT_DIV = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       bit_en = 1'b0;
    logic       txd;
    logic       rts_n;
    logic       eom;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int div = 0;
    int bad_ready = 0;
    int bad_txd = 0;
    int rise_cyc = -1;
    int eom_rise = -1;
    int eom_fall = -1;
    logic rts_prev = 1'b1;
    logic eom_prev = 1'b0;
    logic txd_prev = 1'b1;
    logic be_at_edge = 1'b0;
    logic cap[$];
    int   capc[$];
    logic exp_q[$];
    int   ones_m;

    sdlc_tx_autorts dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .bit_en    (bit_en),
        .txd       (txd),
        .rts_n     (rts_n),
        .eom       (eom)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Bit-rate strobe, changed away from the active edge.
    always @(negedge clk) begin
        if (div == BIT_DIV - 1) begin
            div = 0;
            bit_en = 1'b1;
        end else begin
            div = div + 1;
            bit_en = 1'b0;
        end
    end

    // Record line bits and event times just after each edge.
    always @(posedge clk) begin
        be_at_edge = bit_en;
        #1;
        if (be_at_edge) begin
            cap.push_back(txd);
            capc.push_back(cyc);
        end
        if (rts_n && !rts_prev) rise_cyc = cyc;
        if (eom && !eom_prev) eom_rise = cyc;
        if (!eom && eom_prev) eom_fall = cyc;
        rts_prev = rts_n;
        eom_prev = eom;
    end

    // Port-level slot discipline (R9, R10).
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (in_ready && !bit_en) bad_ready++;
            if (txd !== txd_prev && !be_at_edge) bad_txd++;
        end
        txd_prev = txd;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    task automatic cfg_write(input logic addr, input logic [4:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = addr;
        cfg_wdata = data;
        @(posedge clk);
        #2;
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic b);
        logic [15:0] n;
        n = c >> 1;
        if (c[0] ^ b) n = n ^ 16'h8408;
        return n;
    endfunction

    function automatic void push_st(input logic b);
        if (ones_m == 5) begin
            exp_q.push_back(1'b0);
            ones_m = 0;
        end
        exp_q.push_back(b);
        ones_m = b ? ones_m + 1 : 0;
    endfunction

    function automatic void push_flag();
        if (ones_m == 5) exp_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) exp_q.push_back((8'h7E >> i) & 1'b1);
        ones_m = 0;
    endfunction

    function automatic logic [7:0] pat_byte(input int p, input int i);
        case (p)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h7E;
            default: return 8'(60 + i * 41);
        endcase
    endfunction

    task automatic send_frame(input int n, input int pat, input bit auto_m,
                              input logic [4:0] mode);
        logic [15:0] crc;
        int last_data;
        int s;
        int mism;
        int len;
        cfg_write(1'b1, mode);
        cfg_write(1'b0, 5'd1);
        check(rts_n == 1'b0, "R6", "rts_n after set", rts_n, 0);
        repeat (BIT_DIV * 3) @(posedge clk);
        // Expected frame (R2, R3).
        exp_q.delete();
        ones_m = 0;
        push_flag();
        crc = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                push_st(pat_byte(pat, i)[b]);
                crc = crc_upd(crc, pat_byte(pat, i)[b]);
            end
        end
        last_data = exp_q.size() - 1;
        crc = ~crc;
        for (int b = 0; b < 16; b++) push_st(crc[b]);
        push_flag();
        len = exp_q.size();
        cap.delete();
        capc.delete();
        rise_cyc = -1;
        eom_rise = -1;
        eom_fall = -1;
        // Offer bytes.
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data = pat_byte(pat, i);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        wait (eom == 1'b1);
        cfg_write(1'b0, 5'd0);
        if (auto_m)
            check(rts_n == 1'b0, "R7", "rts_n held after clear", rts_n, 0);
        else
            check(rts_n == 1'b1, "R8", "rts_n after plain clear", rts_n, 1);
        wait (eom == 1'b0);
        repeat (BIT_DIV * 4) @(posedge clk);
        s = -1;
        for (int i = 0; i < cap.size(); i++) begin
            if (cap[i] == 1'b0) begin
                s = i;
                break;
            end
        end
        check(s >= 0, "R2", "frame start seen", s, 0);
        if (s >= 0) begin
            mism = 0;
            for (int i = 0; i < len; i++)
                if (s + i >= cap.size() || cap[s + i] !== exp_q[i]) mism++;
            check(mism == 0, "R2 R3", "frame bit mismatches", mism, 0);
            if (s + len + 1 < cap.size()) begin
                check(cap[s + len] == 1'b1 && cap[s + len + 1] == 1'b1, "R5",
                      "mark after frame", int'(cap[s + len]), 1);
                if (auto_m)
                    check(rise_cyc == capc[s + len], "R7", "rts_n rise cycle",
                          rise_cyc, capc[s + len]);
            end else begin
                check(1'b0, "R5", "capture too short", cap.size(), s + len + 2);
            end
            if (s + last_data < capc.size())
                check(eom_rise == capc[s + last_data], "R4", "eom rise cycle",
                      eom_rise, capc[s + last_data]);
            if (s + len - 1 < capc.size())
                check(eom_fall == capc[s + len - 1], "R4", "eom fall cycle",
                      eom_fall, capc[s + len - 1]);
        end
    endtask

    initial begin
        logic [4:0] plain_modes [4];
        int ones_cnt;
        int per_bad;
        plain_modes[0] = 5'h08;
        plain_modes[1] = 5'h0B;
        plain_modes[2] = 5'h1F;
        plain_modes[3] = 5'h0D;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(txd == 1'b1, "R1", "txd in reset", txd, 1);
        check(rts_n == 1'b1, "R1", "rts_n in reset", rts_n, 1);
        check(eom == 1'b0, "R1", "eom in reset", eom, 0);
        check(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
        rst_n = 1'b1;
        // Flag idle after reset (mode bit 3 = 0), R5.
        repeat (BIT_DIV * 4) @(posedge clk);
        cap.delete();
        repeat (BIT_DIV * 30) @(posedge clk);
        ones_cnt = 0;
        per_bad = 0;
        for (int i = 0; i < 8; i++) ones_cnt += int'(cap[i]);
        for (int i = 0; i < 16; i++) if (cap[i] !== cap[i + 8]) per_bad++;
        check(ones_cnt == 6 && per_bad == 0, "R5", "flag idle pattern", ones_cnt, 6);
        // Sweep frame lengths, payload patterns and RTS modes.
        for (int n = 1; n <= 3; n++)
            for (int p = 0; p < 4; p++)
                for (int a = 0; a < 2; a++)
                    send_frame(n, p, a == 1, (a == 1) ? 5'h0F : plain_modes[p]);
        check(bad_ready == 0, "R10", "in_ready outside bit slot", bad_ready, 0);
        check(bad_txd == 0, "R9", "txd change outside bit slot", bad_txd, 0);
        summary();
    end

endmodule